// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block works out the layout of an attached serial data-flash part when the chip comes out of reset, and then holds that layout for the rest of the session. It drives a byte-level request interface into an SPI serializer that lives outside the block. Each request carries an opcode and the number of response bytes expected, and the serializer returns those bytes one per `rx_vld` strobe.

Detection has two stages. First the block reads the 3-byte identification code and looks it up in an internal table of known devices. If the matched device can run with either a binary or an extended page size, the block then reads the status byte to learn which layout is active. If the manufacturer byte is not the expected one, the block treats the part as an older device and decodes a density field from the status byte instead.

The result is a page count, a page size in bytes and a page-address shift, together with a done flag and a valid/unsupported verdict.

Top module: `flash_geom_probe`

## Requirements
- R1: After reset, the first request is opcode 0x9F with a 3-byte response. Until `det_done` rises, `det_valid`, `det_unsup` and every geometry output read zero.
- R2: The identification key is the first response byte in bits 23:16, then the second and third bytes. Known keys with manufacturer 0x1F: 1F2200 (512 pages), 1F2300 (1024), 1F2400 (2048), 1F2500 (4096) with 264-byte pages and shift 9; 1F2600 (4096) and 1F2701 (8192) with 528-byte pages and shift 10; 1F2800 (8192) with 1056-byte pages and shift 11.
- R3: Every key listed in R2 supports binary pages. After it matches, the block issues a status request (opcode 0xD7, 1 byte). If status bit 0 is 1, the page size is halved to a power of two (256, 512 or 1024) and the shift drops by one. If bit 0 is 0, the extended size of R2 stands.
- R4: Key 1F2700 gives 8192 pages of 528 bytes with shift 10. No status request is issued for it, so only one request is made in total.
- R5: A key with manufacturer 0x1F that is not in the table ends detection as unsupported, with no further request.
- R6: When the manufacturer byte is not 0x1F, the block issues a status request. A status of 0x00 or 0xFF ends detection as unsupported.
- R7: On that fallback path, status bits 5:2 (status AND 0x3C) select the geometry: 0x0C gives 512x264 with shift 9, 0x14 gives 1024x264 with shift 9, 0x1C gives 2048x264 with shift 9, 0x24 gives 4096x264 with shift 9, 0x2C gives 4096x528 with shift 10, and 0x34 gives 8192x528 with shift 10.
- R8: Masked codes 0x38 and 0x3C both give 8192 pages of 1056 bytes with shift 11. Every other masked code is unsupported.
- R9: Once `det_done` is high, it stays high until reset. From then on, the verdict and geometry do not change, exactly one of `det_valid`/`det_unsup` is set, no request is issued, and further response bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | output | 1 | One-cycle request to the serializer |
| xfer_op | output | 8 | Opcode of the request |
| xfer_len | output | 2 | Number of response bytes expected |
| rx_vld | input | 1 | Response byte strobe |
| rx_data | input | 8 | Response byte |
| det_done | output | 1 | Detection finished |
| det_valid | output | 1 | Geometry recognised |
| det_unsup | output | 1 | Device absent or unsupported |
| geo_pages | output | 14 | Number of pages |
| geo_bytes | output | 11 | Page size in bytes |
| geo_shift | output | 4 | Page-address shift |

## Verification
A wrong internal state shows up at the ports within a few cycles of the last response byte:
- A mis-held collection count leaves the block waiting, so `det_done` never rises.
- A wrong path flag produces a missing or extra status request, visible at `xfer_start` one cycle after evaluation.
- A wrong table or decode entry produces a geometry that differs in the cycle `det_done` rises.

The bench compares every run against an independently written table, and counts the requests issued per run. It also feeds stray bytes after completion to show that the held result cannot be disturbed.

// File: rtl/flash_geom_pkg.sv
package flash_geom_pkg;
  localparam int PG_W = 14;
  localparam int SZ_W = 11;
  localparam int SH_W = 4;
  localparam logic [7:0] OP_IDENT  = 8'h9F;
  localparam logic [7:0] OP_STATUS = 8'hD7;
  localparam logic [7:0] MFR_CODE  = 8'h1F;

  typedef struct packed {
    logic            hit;
    logic            bin_ok;
    logic [3:0]      pg_lg2;
    logic [SH_W-1:0] shift;
  } geom_code_t;

  function automatic logic [PG_W-1:0] pages_of(input logic [3:0] lg2);
    return PG_W'(1) << lg2;
  endfunction

  // extended size = 2^(s-1) + 2^(s-6); binary size = 2^(s-1)
  function automatic logic [SZ_W-1:0] bytes_of(input logic [SH_W-1:0] sh, input logic bin);
    logic [SZ_W-1:0] base;
    base = SZ_W'(1) << (sh - SH_W'(1));
    return bin ? base : base + (SZ_W'(1) << (sh - SH_W'(6)));
  endfunction

  function automatic logic [SH_W-1:0] shift_of(input logic [SH_W-1:0] sh, input logic bin);
    return bin ? sh - SH_W'(1) : sh;
  endfunction
endpackage

// File: rtl/flash_id_table.sv
module flash_id_table
  import flash_geom_pkg::*;
(
  input  logic [23:0] key,
  output geom_code_t  code
);
  always_comb begin
    code = '0;
    unique case (key)
      24'h1F2200: code = '{1'b1, 1'b1, 4'd9,  SH_W'(9)};
      24'h1F2300: code = '{1'b1, 1'b1, 4'd10, SH_W'(9)};
      24'h1F2400: code = '{1'b1, 1'b1, 4'd11, SH_W'(9)};
      24'h1F2500: code = '{1'b1, 1'b1, 4'd12, SH_W'(9)};
      24'h1F2600: code = '{1'b1, 1'b1, 4'd12, SH_W'(10)};
      24'h1F2700: code = '{1'b1, 1'b0, 4'd13, SH_W'(10)};
      24'h1F2701: code = '{1'b1, 1'b1, 4'd13, SH_W'(10)};
      24'h1F2800: code = '{1'b1, 1'b1, 4'd13, SH_W'(11)};
      default:    code = '0;
    endcase
  end
endmodule

// File: rtl/flash_density_decode.sv
module flash_density_decode
  import flash_geom_pkg::*;
(
  input  logic [7:0] status,
  output geom_code_t code
);
  logic absent;
  assign absent = (status == 8'h00) || (status == 8'hFF);

  always_comb begin
    code = '0;
    if (!absent) begin
      unique case (status & 8'h3C)
        8'h0C:        code = '{1'b1, 1'b0, 4'd9,  SH_W'(9)};
        8'h14:        code = '{1'b1, 1'b0, 4'd10, SH_W'(9)};
        8'h1C:        code = '{1'b1, 1'b0, 4'd11, SH_W'(9)};
        8'h24:        code = '{1'b1, 1'b0, 4'd12, SH_W'(9)};
        8'h2C:        code = '{1'b1, 1'b0, 4'd12, SH_W'(10)};
        8'h34:        code = '{1'b1, 1'b0, 4'd13, SH_W'(10)};
        8'h38, 8'h3C: code = '{1'b1, 1'b0, 4'd13, SH_W'(11)};
        default:      code = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_geom_probe.sv
module flash_geom_probe
  import flash_geom_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic            xfer_start,
  output logic [7:0]      xfer_op,
  output logic [1:0]      xfer_len,
  input  logic            rx_vld,
  input  logic [7:0]      rx_data,
  output logic            det_done,
  output logic            det_valid,
  output logic            det_unsup,
  output logic [PG_W-1:0] geo_pages,
  output logic [SZ_W-1:0] geo_bytes,
  output logic [SH_W-1:0] geo_shift
);
  typedef enum logic [2:0] {
    S_BOOT, S_ID_REQ, S_ID_RX, S_ID_EVAL, S_ST_REQ, S_ST_RX, S_ST_EVAL, S_DONE
  } state_t;

  state_t     state;
  logic [1:0] rx_cnt;
  logic [23:0] id_q;
  logic [7:0] st_q;
  logic       legacy_q;
  geom_code_t id_code, leg_code, keep_q;

  flash_id_table       u_table  (.key(id_q), .code(id_code));
  flash_density_decode u_decode (.status(st_q), .code(leg_code));

  // named events for the checks
  logic mfr_ok, id_unknown, id_fixed, id_refine, id_legacy;
  assign mfr_ok     = (id_q[23:16] == MFR_CODE);
  assign id_unknown = (state == S_ID_EVAL) && mfr_ok && !id_code.hit;
  assign id_fixed   = (state == S_ID_EVAL) && mfr_ok && id_code.hit && !id_code.bin_ok;
  assign id_refine  = (state == S_ID_EVAL) && mfr_ok && id_code.hit && id_code.bin_ok;
  assign id_legacy  = (state == S_ID_EVAL) && !mfr_ok;

  assign xfer_start = (state == S_ID_REQ) || (state == S_ST_REQ);
  assign xfer_op    = (state == S_ST_REQ) ? OP_STATUS : OP_IDENT;
  assign xfer_len   = (state == S_ST_REQ) ? 2'd1 : 2'd3;
  assign det_done   = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_BOOT;
      rx_cnt    <= '0;
      id_q      <= '0;
      st_q      <= '0;
      legacy_q  <= 1'b0;
      keep_q    <= '0;
      det_valid <= 1'b0;
      det_unsup <= 1'b0;
      geo_pages <= '0;
      geo_bytes <= '0;
      geo_shift <= '0;
    end else begin
      unique case (state)
        S_BOOT:   state <= S_ID_REQ;
        S_ID_REQ: begin
          rx_cnt <= '0;
          state  <= S_ID_RX;
        end
        S_ID_RX: if (rx_vld) begin
          id_q   <= {id_q[15:0], rx_data};
          rx_cnt <= rx_cnt + 2'd1;
          if (rx_cnt == 2'd2) state <= S_ID_EVAL;
        end
        S_ID_EVAL: begin
          keep_q <= id_code;
          if (id_legacy) begin
            legacy_q <= 1'b1;
            state    <= S_ST_REQ;
          end else if (id_refine) begin
            legacy_q <= 1'b0;
            state    <= S_ST_REQ;
          end else if (id_fixed) begin
            det_valid <= 1'b1;
            geo_pages <= pages_of(id_code.pg_lg2);
            geo_bytes <= bytes_of(id_code.shift, 1'b0);
            geo_shift <= shift_of(id_code.shift, 1'b0);
            state     <= S_DONE;
          end else begin
            det_unsup <= 1'b1;
            state     <= S_DONE;
          end
        end
        S_ST_REQ: state <= S_ST_RX;
        S_ST_RX: if (rx_vld) begin
          st_q  <= rx_data;
          state <= S_ST_EVAL;
        end
        S_ST_EVAL: begin
          state <= S_DONE;
          if (legacy_q) begin
            if (leg_code.hit) begin
              det_valid <= 1'b1;
              geo_pages <= pages_of(leg_code.pg_lg2);
              geo_bytes <= bytes_of(leg_code.shift, 1'b0);
              geo_shift <= shift_of(leg_code.shift, 1'b0);
            end else begin
              det_unsup <= 1'b1;
            end
          end else begin
            det_valid <= 1'b1;
            geo_pages <= pages_of(keep_q.pg_lg2);
            geo_bytes <= bytes_of(keep_q.shift, st_q[0]);
            geo_shift <= shift_of(keep_q.shift, st_q[0]);
          end
        end
        S_DONE:  state <= S_DONE;
        default: state <= S_BOOT;
      endcase
    end
  end

  a_r1_legal_request: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> ((xfer_op == OP_IDENT && xfer_len == 2'd3) ||
                    (xfer_op == OP_STATUS && xfer_len == 2'd1)));
  a_r1_quiet_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    !det_done |-> (!det_valid && !det_unsup && geo_pages == '0));
  a_r3_refine_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    id_refine |=> (xfer_start && xfer_op == OP_STATUS));
  a_r4_fixed_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    id_fixed |=> (det_done && det_valid && !xfer_start));
  a_r5_unknown_stops: assert property (@(posedge clk) disable iff (!rst_n)
    id_unknown |=> (det_done && det_unsup));
  a_r6_legacy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    id_legacy |=> (xfer_start && xfer_op == OP_STATUS));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |=> (det_done && $stable(det_valid) && $stable(geo_pages) &&
                  $stable(geo_bytes) && $stable(geo_shift)));
  a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> (det_valid != det_unsup));
  a_r9_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> !xfer_start);
endmodule

// File: tb/test_flash_geom_probe.sv
module test_flash_geom_probe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_vld = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        xfer_start, det_done, det_valid, det_unsup;
  logic [7:0]  xfer_op;
  logic [1:0]  xfer_len;
  logic [13:0] geo_pages;
  logic [10:0] geo_bytes;
  logic [3:0]  geo_shift;

  always #4 clk = ~clk;

  flash_geom_probe i_flash_geom_probe (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_op(xfer_op),
    .xfer_len(xfer_len), .rx_vld(rx_vld), .rx_data(rx_data),
    .det_done(det_done), .det_valid(det_valid), .det_unsup(det_unsup),
    .geo_pages(geo_pages), .geo_bytes(geo_bytes), .geo_shift(geo_shift));

  typedef struct packed {
    logic [7:0]  tag;
    logic        ok;
    logic [13:0] pages;
    logic [10:0] bytes;
    logic [3:0]  shift;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  int   cycles = 0;

  task automatic check(input bit good, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    bit seen = 0;
    forever begin
      @(negedge clk);
      if (!det_done) seen = 0;
      else if (!seen) begin
        exp_t e;
        seen = 1;
        if (exp_q.size() == 0) check(0, "R9", "unexpected result", 1, 0);
        else begin
          e = exp_q.pop_front();
          $display("run %0d", e.tag);
          check(det_valid == e.ok && det_unsup == !e.ok, "R2-verdict", "valid",
                int'(det_valid), int'(e.ok));
          if (e.ok) begin
            check(geo_pages == e.pages, "R2 pages", "pages", int'(geo_pages), int'(e.pages));
            check(geo_bytes == e.bytes, "R3 bytes", "bytes", int'(geo_bytes), int'(e.bytes));
            check(geo_shift == e.shift, "R7 shift", "shift", int'(geo_shift), int'(e.shift));
          end
        end
      end
    end
  end

  task automatic feed(input logic [7:0] b);
    @(negedge clk); rx_vld = 1'b1; rx_data = b;
    @(negedge clk); rx_vld = 1'b0;
  endtask

  task automatic run(input logic [7:0] tag, input logic [23:0] id, input logic [7:0] st,
                     input logic ok, input int pages, input int bytes, input int shift,
                     input int nreq);
    int n = 0;
    exp_q.push_back('{tag, ok, 14'(pages), 11'(bytes), 4'(shift)});
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!det_done && !det_valid && !det_unsup && geo_pages == 0 && !xfer_start,
          "R1", "reset state", int'(det_done), 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (det_done) break;
      if (xfer_start) begin
        n++;
        if (n == 1) begin
          check(xfer_op == 8'h9F && xfer_len == 2'd3, "R1", "first op", int'(xfer_op), 'h9F);
          feed(id[23:16]); feed(id[15:8]); @(negedge clk); feed(id[7:0]);
        end else begin
          check(xfer_op == 8'hD7 && xfer_len == 2'd1, "R3", "status op", int'(xfer_op), 'hD7);
          @(negedge clk); feed(st);
        end
      end
    end
    check(n == nreq, "R4 R5", "request count", n, nreq);
    // stray bytes after completion must not disturb the result (R9)
    feed(8'h2C); feed(8'hFF);
    repeat (2) @(negedge clk);
    check(det_done && !xfer_start && det_valid == ok, "R9", "held verdict",
          int'(det_valid), int'(ok));
    if (ok) check(geo_pages == 14'(pages) && geo_bytes == 11'(bytes), "R9", "held geometry",
                  int'(geo_bytes), bytes);
  endtask

  initial begin
    run(1, 24'h1F2400, 8'h80, 1, 2048, 264, 9, 2);   // R3 extended
    run(2, 24'h1F2400, 8'h81, 1, 2048, 256, 8, 2);   // R3 binary
    run(3, 24'h1F2200, 8'h00, 1, 512, 264, 9, 2);    // R2
    run(4, 24'h1F2600, 8'h01, 1, 4096, 512, 9, 2);   // R3
    run(5, 24'h1F2800, 8'h01, 1, 8192, 1024, 10, 2); // R3
    run(6, 24'h1F2800, 8'h00, 1, 8192, 1056, 11, 2); // R2
    run(7, 24'h1F2701, 8'h81, 1, 8192, 512, 9, 2);   // R2 R3
    run(8, 24'h1F2700, 8'h81, 1, 8192, 528, 10, 1);  // R4
    run(9, 24'h1F9900, 8'h81, 0, 0, 0, 0, 1);        // R5
    run(10, 24'h000000, 8'h2C, 1, 4096, 528, 10, 2); // R7
    run(11, 24'hFFFFFF, 8'h0C, 1, 512, 264, 9, 2);   // R7
    run(12, 24'h7F0000, 8'hB4, 1, 8192, 528, 10, 2); // R7
    run(13, 24'h000000, 8'hB8, 1, 8192, 1056, 11, 2);// R8
    run(14, 24'h000000, 8'h3C, 1, 8192, 1056, 11, 2);// R8
    run(15, 24'h000000, 8'h10, 0, 0, 0, 0, 2);       // R8 unsupported code
    run(16, 24'h000000, 8'hFF, 0, 0, 0, 0, 2);       // R6
    run(17, 24'h000000, 8'h00, 0, 0, 0, 0, 2);       // R6
    run(18, 24'h1E2400, 8'h24, 1, 4096, 264, 9, 2);  // R6 R7 wrong maker
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule